// File: doc/BRIEF.md
# Vector Lane to Scalar Mover

This unit carries out the two "copy one vector element into a general register" operations: a signed form that sign-extends the element and an unsigned form that zero-extends it. Each cycle it takes a 32-bit instruction word, the 128-bit value of the source vector register and a valid strobe. When the word is one of the two operations, the unit decodes the element size and the lane number, extracts that lane, widens it, and presents a 64-bit write value with a write enable and a flag telling whether the destination is 32 or 64 bits wide.

The element size comes from a 5-bit immediate field. Its lowest set bit picks the size, and the bits above that bit give the lane number. The signed and unsigned forms accept different pairs of element size and destination width. A valid word of either form whose pair is not accepted raises an unallocated-encoding flag and writes nothing. Words of any other kind pass through with no effect. The outputs are registered, so results appear one clock after the inputs. A parameter removes that register stage when the surrounding pipeline supplies its own.

Top module: `lane_to_gpr_mover`

## Requirements
- R1: An instruction word is taken only when bits 29..21 equal 0x070 and bits 15..10 equal 0x0B (signed form) or 0x0F (unsigned form). Any other word, even with in_valid high, gives out_wen=0 and out_unalloc=0.
- R2: The immediate is bits 20..16. Its lowest set bit among bits 0..3 sets the element size: bit 0 gives a byte with lane bits 4..1, bit 1 a halfword with lane bits 4..2, bit 2 a word with lane bits 4..3, and bit 3 a doubleword with lane bit 4. Lanes are little-endian: lane k of an element of N bits occupies vector bits k*N+N-1..k*N.
- R3: The signed form accepts byte and halfword elements with either destination width. It accepts word elements only when bit 30 is 1 (64-bit destination). Every other combination raises out_unalloc.
- R4: With bit 30 = 0, the unsigned form accepts byte, halfword and word elements. With bit 30 = 1 it accepts only doubleword elements. Every other combination raises out_unalloc.
- R5: An immediate with none of bits 0..3 set is unallocated in both forms, whatever bit 30 is.
- R6: The signed form sign-extends the element to 32 bits when bit 30 = 0 and to 64 bits when bit 30 = 1.
- R7: The unsigned form zero-extends the element to the destination width.
- R8: On a write, out_is64 equals instruction bit 30. A 32-bit write leaves out_wdata bits 63..32 at zero.
- R9: When out_unalloc is high, out_wen, out_is64 and out_wdata are all zero.
- R10: Outputs are registered with a latency of one clock. With in_valid low the next outputs are all zero, and reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and vector value are valid this cycle |
| insn | input | 32 | Instruction word |
| vec_src | input | 128 | Source vector register value |
| out_wdata | output | 64 | Value to write to the general register |
| out_wen | output | 1 | General-register write enable |
| out_is64 | output | 1 | Write is 64 bits wide (0: 32 bits) |
| out_unalloc | output | 1 | Unallocated size and width combination seen |

## Verification
The checker watches every cycle for the invariants that hold whatever the instruction is. An unallocated flag never comes with a write, the width flag never rises without a write, a narrow write always has a clear upper half, and a cycle with no valid input is followed by quiet outputs. Whether the right lane was picked, whether it was widened with the right sign, and which size and width pairs each form accepts can only be shown by the bench. The bench sweeps every immediate value with both destination widths and both forms over several vector patterns, and compares each result against an arithmetic model.

// File: rtl/mover_pkg.sv
package mover_pkg;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esize_e;

  typedef struct packed {
    logic       hit;        // word is one of the two move forms
    logic       is_signed;  // signed form
    logic       wide;       // 64-bit destination
    logic       legal;      // size/width pair accepted
    esize_e     size;
    logic [3:0] lane;       // lane number, right-aligned
  } mv_dec_t;

  localparam logic [8:0] OPC_HI   = 9'h070;
  localparam logic [5:0] OPC_SGN  = 6'h0B;
  localparam logic [5:0] OPC_UNS  = 6'h0F;

endpackage

// File: rtl/mover_decode.sv
module mover_decode
  import mover_pkg::*;
(
  input  logic [31:0] insn,
  output mv_dec_t     dec
);

  logic [4:0] imm;
  logic       sz_ok;
  esize_e     sz;
  logic [3:0] ln;

  assign imm = insn[20:16];

  // lowest set bit of the immediate picks the element size
  always_comb begin
    sz_ok = 1'b1;
    sz    = ESZ_B;
    ln    = 4'd0;
    if (imm[0]) begin
      sz = ESZ_B;
      ln = imm[4:1];
    end else if (imm[1]) begin
      sz = ESZ_H;
      ln = {1'b0, imm[4:2]};
    end else if (imm[2]) begin
      sz = ESZ_W;
      ln = {2'b0, imm[4:3]};
    end else if (imm[3]) begin
      sz = ESZ_D;
      ln = {3'b0, imm[4]};
    end else begin
      sz_ok = 1'b0;
    end
  end

  always_comb begin
    dec.hit       = (insn[29:21] == OPC_HI) &&
                    ((insn[15:10] == OPC_SGN) || (insn[15:10] == OPC_UNS));
    dec.is_signed = (insn[15:10] == OPC_SGN);
    dec.wide      = insn[30];
    dec.size      = sz;
    dec.lane      = ln;
    if (!sz_ok) begin
      dec.legal = 1'b0;
    end else if (dec.is_signed) begin
      dec.legal = (sz == ESZ_B) || (sz == ESZ_H) || ((sz == ESZ_W) && insn[30]);
    end else begin
      dec.legal = insn[30] ? (sz == ESZ_D) : (sz != ESZ_D);
    end
  end

endmodule

// File: rtl/mover_lane_pick.sv
module mover_lane_pick
  import mover_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] vec,
  input  esize_e           size,
  input  logic [3:0]       lane,
  output logic [63:0]      elem
);

  localparam int N8  = VEC_W / 8;
  localparam int N16 = VEC_W / 16;
  localparam int N32 = VEC_W / 32;
  localparam int N64 = VEC_W / 64;
  localparam int IW8  = $clog2(N8);
  localparam int IW16 = $clog2(N16);
  localparam int IW32 = $clog2(N32);
  localparam int IW64 = (N64 > 1) ? $clog2(N64) : 1;

  logic [7:0]  l8  [N8];
  logic [15:0] l16 [N16];
  logic [31:0] l32 [N32];
  logic [63:0] l64 [N64];

  for (genvar g = 0; g < N8; g++) begin : g_b
    assign l8[g] = vec[g*8 +: 8];
  end
  for (genvar g = 0; g < N16; g++) begin : g_h
    assign l16[g] = vec[g*16 +: 16];
  end
  for (genvar g = 0; g < N32; g++) begin : g_w
    assign l32[g] = vec[g*32 +: 32];
  end
  for (genvar g = 0; g < N64; g++) begin : g_d
    assign l64[g] = vec[g*64 +: 64];
  end

  always_comb begin
    unique case (size)
      ESZ_B:   elem = {56'b0, l8[lane[IW8-1:0]]};
      ESZ_H:   elem = {48'b0, l16[lane[IW16-1:0]]};
      ESZ_W:   elem = {32'b0, l32[lane[IW32-1:0]]};
      default: elem = l64[lane[IW64-1:0]];
    endcase
  end

endmodule

// File: rtl/mover_extend.sv
module mover_extend
  import mover_pkg::*;
(
  input  logic [63:0] raw,
  input  esize_e      size,
  input  logic        is_signed,
  input  logic        wide,
  output logic [63:0] data
);

  logic [63:0] keep;
  logic        msb;
  logic [63:0] full;

  always_comb begin
    unique case (size)
      ESZ_B:   begin keep = 64'h0000_0000_0000_00FF; msb = raw[7];  end
      ESZ_H:   begin keep = 64'h0000_0000_0000_FFFF; msb = raw[15]; end
      ESZ_W:   begin keep = 64'h0000_0000_FFFF_FFFF; msb = raw[31]; end
      default: begin keep = 64'hFFFF_FFFF_FFFF_FFFF; msb = raw[63]; end
    endcase
    full = (raw & keep) | ((is_signed && msb) ? ~keep : 64'b0);
    data = wide ? full : {32'b0, full[31:0]};
  end

endmodule

// File: rtl/lane_to_gpr_mover.sv
module lane_to_gpr_mover
  import mover_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int GPR_W   = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      insn,
  input  logic [VEC_W-1:0] vec_src,
  output logic [GPR_W-1:0] out_wdata,
  output logic             out_wen,
  output logic             out_is64,
  output logic             out_unalloc
);

  mv_dec_t     dec;
  logic [63:0] elem;
  logic [63:0] ext;
  logic        fire;
  logic        nx_wen, nx_un, nx_is64;
  logic [GPR_W-1:0] nx_data;

  mover_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  mover_lane_pick #(.VEC_W(VEC_W)) u_pick (
    .vec  (vec_src),
    .size (dec.size),
    .lane (dec.lane),
    .elem (elem)
  );

  mover_extend u_ext (
    .raw       (elem),
    .size      (dec.size),
    .is_signed (dec.is_signed),
    .wide      (dec.wide),
    .data      (ext)
  );

  assign fire    = in_valid && dec.hit;
  assign nx_wen  = fire && dec.legal;
  assign nx_un   = fire && !dec.legal;
  assign nx_is64 = nx_wen && dec.wide;
  assign nx_data = nx_wen ? ext[GPR_W-1:0] : '0;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_wdata   <= '0;
        out_wen     <= 1'b0;
        out_is64    <= 1'b0;
        out_unalloc <= 1'b0;
      end else begin
        out_wdata   <= nx_data;
        out_wen     <= nx_wen;
        out_is64    <= nx_is64;
        out_unalloc <= nx_un;
      end
    end
  end else begin : g_comb
    assign out_wdata   = nx_data;
    assign out_wen     = nx_wen;
    assign out_is64    = nx_is64;
    assign out_unalloc = nx_un;
  end

endmodule

// File: rtl/mover_checker.sv
module mover_checker #(
  parameter int GPR_W   = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [GPR_W-1:0] out_wdata,
  input logic             out_wen,
  input logic             out_is64,
  input logic             out_unalloc
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_UNALLOC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_unalloc |-> (!out_wen && !out_is64 && out_wdata == '0)); // R9

  AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (out_wen && !out_is64) |-> (out_wdata[GPR_W-1:32] == '0)); // R8

  AST_WIDE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_is64 |-> out_wen); // R8

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_wen, out_unalloc})); // R9

  if (OUT_REG) begin : g_lat
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(in_valid)) |-> (!out_wen && !out_unalloc && out_wdata == '0)); // R10
  end

endmodule

bind lane_to_gpr_mover mover_checker #(.GPR_W(GPR_W), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .out_wdata   (out_wdata),
  .out_wen     (out_wen),
  .out_is64    (out_is64),
  .out_unalloc (out_unalloc)
);

// File: tb/lane_to_gpr_mover_test.sv
module lane_to_gpr_mover_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] vec_src = '0;
  logic [63:0]  out_wdata;
  logic         out_wen, out_is64, out_unalloc;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_to_gpr_mover #(.VEC_W(128), .GPR_W(64), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .vec_src(vec_src),
    .out_wdata(out_wdata), .out_wen(out_wen), .out_is64(out_is64),
    .out_unalloc(out_unalloc)
  );

  function automatic logic [31:0] enc(input bit sgn, input bit w64, input logic [4:0] imm);
    return {1'b0, w64, 9'h070, imm, (sgn ? 6'h0B : 6'h0F), 5'd3, 5'd7};
  endfunction

  // arithmetic reference model
  task automatic model(input logic v, input logic [31:0] w, input logic [127:0] x,
                       output logic e_wen, output logic e_un, output logic e_64,
                       output logic [63:0] e_d, output string tag);
    bit hit, sgn, w64, legal;
    int sz, bits, idx;
    logic [4:0] imm;
    logic [127:0] msk, el;
    logic [63:0] full;
    hit = (w[29:21] == 9'h070) && (w[15:10] == 6'h0B || w[15:10] == 6'h0F);
    sgn = (w[15:10] == 6'h0B);
    w64 = w[30];
    imm = w[20:16];
    sz = 4;
    for (int b = 3; b >= 0; b--) if (imm[b]) sz = b;
    if (sz == 4) legal = 0;
    else if (sgn) legal = (sz < 2) || (sz == 2 && w64);
    else legal = w64 ? (sz == 3) : (sz <= 2);
    e_wen = 0; e_un = 0; e_64 = 0; e_d = '0;
    tag = !hit ? "R1" : (sz == 4) ? "R5" : !legal ? (sgn ? "R3" : "R4") : (sgn ? "R6" : "R7");
    if (!v) begin tag = "R10"; return; end
    if (!hit) return;
    if (!legal) begin e_un = 1; return; end
    bits = 8 << sz;
    idx  = int'(imm) >> (sz + 1);
    msk  = (128'd1 << bits) - 128'd1;
    el   = (x >> (idx * bits)) & msk;
    full = el[63:0];
    if (sgn && el[bits-1]) full = full | ~msk[63:0];
    e_wen = 1;
    e_64  = w64;
    e_d   = w64 ? full : {32'b0, full[31:0]};
  endtask

  task automatic check(input string tag, input logic [63:0] d, input logic wn,
                       input logic s64, input logic un);
    n_run++;
    if (out_wdata !== d || out_wen !== wn || out_is64 !== s64 || out_unalloc !== un) begin
      n_fail++;
      $display("FAIL %s: got data=%h wen=%b is64=%b un=%b, expected data=%h wen=%b is64=%b un=%b",
               tag, out_wdata, out_wen, out_is64, out_unalloc, d, wn, s64, un);
    end
  endtask

  task automatic apply(input logic v, input logic [31:0] w, input logic [127:0] x,
                       input string force_tag);
    logic ew, eu, e6;
    logic [63:0] ed;
    string tg;
    model(v, w, x, ew, eu, e6, ed, tg);
    if (force_tag != "") tg = force_tag;
    @(negedge clk);
    in_valid = v; insn = w; vec_src = x;
    @(negedge clk);
    check(tg, ed, ew, e6, eu);
  endtask

  function automatic logic [127:0] pat(input int k);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      case (k)
        0: r[i*8 +: 8] = 8'h80 + 8'(i * 17);
        1: r[i*8 +: 8] = ~(8'h80 + 8'(i * 17));
        2: r[i*8 +: 8] = 8'(i * 37 + 5) ^ 8'h5A;
        default: r[i*8 +: 8] = (i % 2 == 1) ? 8'hFF : 8'h01;
      endcase
    end
    return r;
  endfunction

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", 64'd0, 1'b0, 1'b0, 1'b0); // reset state
    rst = 1'b0;

    // R2 explicit lane placement: unsigned halfword lane 5 -> bits 95..80
    apply(1'b1, enc(1'b0, 1'b0, 5'b10110), 128'h0000_0000_BEEF_0000_0000_0000_0000_0000, "R2");
    // R8 signed byte to 32-bit clears upper half
    apply(1'b1, enc(1'b1, 1'b0, 5'b00001), 128'h80, "R8");
    // R8 signed byte to 64-bit fills upper half
    apply(1'b1, enc(1'b1, 1'b1, 5'b00001), 128'h80, "R8");
    // R9 unallocated writes nothing
    apply(1'b1, enc(1'b0, 1'b1, 5'b00100), pat(0), "R9");
    // R10 invalid strobe gives quiet outputs
    apply(1'b0, enc(1'b0, 1'b0, 5'b00001), pat(0), "R10");
    // R1 near-miss encodings
    apply(1'b1, enc(1'b0, 1'b0, 5'b00001) ^ 32'h0020_0000, pat(0), "R1");
    apply(1'b1, {1'b0, 1'b0, 9'h070, 5'b00001, 6'h0C, 10'd0}, pat(0), "R1");
    apply(1'b1, {1'b0, 1'b1, 9'h070, 5'b01000, 6'h07, 10'd0}, pat(1), "R1");

    // sweep: every immediate, both widths, both forms, several vectors
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
          for (int m = 0; m < 32; m++)
            apply(1'b1, enc(s[0], w[0], 5'(m)), pat(k), "");

    // back-to-back with idle gaps
    for (int m = 0; m < 32; m++) begin
      apply(1'b1, enc(1'b1, m[0], 5'(m)), pat(2), "");
      apply(1'b0, enc(1'b1, m[0], 5'(m)), pat(2), "");
    end

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule